// File: doc/BRIEF.md
# Calendar Clock With Write-Busy Flags

This block keeps wall-clock time and a calendar date in two packed 32-bit registers. The value advances on a one-cycle tick pulse that arrives once per second. Hours, minutes and seconds sit in one word. Day, month, a six-bit year offset and a leap-year flag sit in the other. A plain strobe bus reads and writes the words. The read data is combinational on the address.

A bus write to the time word or the date word does not change the clock at once. The value is held in a pending slot and is committed a fixed number of clock cycles later. While the commit is outstanding, a busy flag for that word is set in the control word. Further writes to that word are dropped until the flag clears.

The year offset counts from 1970, so 0 is 1970 and 63 is 2033. The hardware does not work out leap years. Software supplies the leap flag together with the date, and February's length follows that stored bit. The time and date words can change between two reads. Software must therefore re-read both words until two passes agree.

Top module: `cal_clock`

## Requirements
- R1: After reset the time word reads 0, the date word reads 0x00000101 (day 1, month 1, year 0, leap 0), and the control word reads 0.
- R2: The time word at 0x14 holds seconds in bits 5:0, minutes in bits 13:8 and hours in bits 20:16. Every other bit reads 0, so writing 0xFFFFFFFF and letting it commit reads back 0x001F3F3F.
- R3: The date word at 0x10 holds day in bits 4:0, month (1 to 12) in bits 11:8, year offset in bits 21:16 and the leap flag in bit 22. Every other bit reads 0, so writing 0xFFFFFFFF and letting it commit reads back 0x007F0F1F.
- R4: A write to the time word sets control bit 8. A write to the date word sets control bit 7. The flag reads 1 for COMMIT_CYCLES (default 2) clock cycles after the write edge, and the old value stays visible during that time. On the edge where the flag clears, the written value appears.
- R5: A write to a word whose busy flag is set is ignored. The value first accepted is the one committed.
- R6: On a tick, seconds go from 59 to 0 and carry into minutes. Minutes go from 59 to 0 and carry into hours. Hours go from 23 to 0 and carry into the day.
- R7: A day carry past day 31 in months 1, 3, 5, 7, 8, 10 and 12, or past day 30 in months 4, 6, 9 and 11, sets the day to 1 and advances the month. Below those limits the day only increments.
- R8: In month 2 the day wraps after day 28 when the leap flag is 0 and after day 29 when it is 1. The leap flag keeps its value across the carry.
- R9: A month carry from 12 sets the month to 1 and advances the year. Year 63 wraps to 0.
- R10: Without a tick or a commit, neither the time word nor the date word changes.
- R11: The control word cannot be written. Reads of any address other than 0x00, 0x10 and 0x14 return 0. Writes to such addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse, once per second |
| wr | input | 1 | Write strobe |
| addr | input | AW (8) | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |

## Verification
A fault in the carry chain shows in the word read back right after the tick that crosses the boundary. The stimulus sets each boundary directly through the bus, so a wrong month length or a missed year wrap appears after a single tick, not after days of simulated time. A commit counter that is off by one shows the busy flag or the old value one cycle early or late, in the reads taken on each cycle after the write. A dropped write-while-busy rule shows the second written value in place of the first once the commit lands.

// File: rtl/cal_clock.sv
module cal_clock #(
  parameter int COMMIT_CYCLES = 2,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);
  localparam int CW = $clog2(COMMIT_CYCLES + 1);
  localparam logic [AW-1:0] A_CTRL = AW'('h00);
  localparam logic [AW-1:0] A_DATE = AW'('h10);
  localparam logic [AW-1:0] A_TIME = AW'('h14);

  logic [5:0] sec, min, yr;
  logic [4:0] hr, day;
  logic [3:0] mon;
  logic       leap;

  logic [16:0] pend_t;
  logic [15:0] pend_d;
  logic        bsy_t, bsy_d;
  logic [CW-1:0] cnt_t, cnt_d;

  logic wr_t, wr_d, commit_t, commit_d;
  assign wr_t     = wr && addr == A_TIME && !bsy_t;
  assign wr_d     = wr && addr == A_DATE && !bsy_d;
  assign commit_t = bsy_t && cnt_t == CW'(1);
  assign commit_d = bsy_d && cnt_d == CW'(1);

  logic unused_wdata;
  assign unused_wdata = ^{wdata[31:23], wdata[15:14], wdata[7:6]};

  logic       sec_wrap, min_wrap, hr_wrap, day_wrap, mon_wrap;
  logic [4:0] mdays;
  assign sec_wrap = sec == 6'd59;
  assign min_wrap = sec_wrap && min == 6'd59;
  assign hr_wrap  = min_wrap && hr == 5'd23;
  assign mdays    = (mon == 4'd2) ? (leap ? 5'd29 : 5'd28) :
                    (mon == 4'd4 || mon == 4'd6 || mon == 4'd9 || mon == 4'd11) ? 5'd30 : 5'd31;
  assign day_wrap = hr_wrap && day >= mdays;
  assign mon_wrap = day_wrap && mon >= 4'd12;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec <= '0; min <= '0; hr <= '0;
    end else if (commit_t) begin
      sec <= pend_t[5:0];
      min <= pend_t[11:6];
      hr  <= pend_t[16:12];
    end else if (tick) begin
      sec <= sec_wrap ? 6'd0 : sec + 6'd1;
      if (sec_wrap) min <= (min == 6'd59) ? 6'd0 : min + 6'd1;
      if (min_wrap) hr  <= (hr == 5'd23) ? 5'd0 : hr + 5'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      day <= 5'd1; mon <= 4'd1; yr <= '0; leap <= 1'b0;
    end else if (commit_d) begin
      day  <= pend_d[4:0];
      mon  <= pend_d[8:5];
      yr   <= pend_d[14:9];
      leap <= pend_d[15];
    end else if (tick && hr_wrap) begin
      day <= day_wrap ? 5'd1 : day + 5'd1;
      if (day_wrap) mon <= mon_wrap ? 4'd1 : mon + 4'd1;
      if (mon_wrap) yr  <= yr + 6'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bsy_t <= 1'b0; cnt_t <= '0; pend_t <= '0;
    end else if (wr_t) begin
      bsy_t  <= 1'b1;
      cnt_t  <= CW'(COMMIT_CYCLES);
      pend_t <= {wdata[20:16], wdata[13:8], wdata[5:0]};
    end else if (commit_t) begin
      bsy_t <= 1'b0;
    end else if (bsy_t) begin
      cnt_t <= cnt_t - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bsy_d <= 1'b0; cnt_d <= '0; pend_d <= '0;
    end else if (wr_d) begin
      bsy_d  <= 1'b1;
      cnt_d  <= CW'(COMMIT_CYCLES);
      pend_d <= {wdata[22], wdata[21:16], wdata[11:8], wdata[4:0]};
    end else if (commit_d) begin
      bsy_d <= 1'b0;
    end else if (bsy_d) begin
      cnt_d <= cnt_d - CW'(1);
    end
  end

  logic [31:0] time_word, date_word, ctrl_word;
  assign time_word = {11'b0, hr, 2'b0, min, 2'b0, sec};
  assign date_word = {9'b0, leap, yr, 4'b0, mon, 3'b0, day};
  assign ctrl_word = {22'b0, 1'b0, bsy_t, bsy_d, 7'b0};

  assign rdata = (addr == A_TIME) ? time_word :
                 (addr == A_DATE) ? date_word :
                 (addr == A_CTRL) ? ctrl_word : 32'h0;
endmodule

// File: rtl/cal_clock_chk.sv
module cal_clock_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          wr,
  input logic [AW-1:0] addr,
  input logic [31:0]   wdata,
  input logic          bsy_t,
  input logic          bsy_d,
  input logic          commit_t,
  input logic          commit_d,
  input logic [16:0]   pend_t,
  input logic [15:0]   pend_d,
  input logic [31:0]   time_word,
  input logic [31:0]   date_word
);
  localparam logic [AW-1:0] A_TIME = AW'('h14);

  a_r4_time_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_TIME && !bsy_t) |=> (bsy_t && pend_t == {$past(wdata[20:16]), $past(wdata[13:8]), $past(wdata[5:0])}));

  a_r4_time_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bsy_t) |-> time_word == {11'b0, pend_t[16:12], 2'b0, pend_t[11:6], 2'b0, pend_t[5:0]});

  a_r4_date_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bsy_d) |-> date_word == {9'b0, pend_d[15], pend_d[14:9], 4'b0, pend_d[8:5], 3'b0, pend_d[4:0]});

  a_r5_time_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
    bsy_t |=> $stable(pend_t));

  a_r5_date_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
    bsy_d |=> $stable(pend_d));

  a_r6_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !commit_t && time_word[5:0] == 6'd59) |=> time_word[5:0] == 6'd0);

  a_r10_time_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !commit_t) |=> $stable(time_word));

  a_r10_date_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !commit_d) |=> $stable(date_word));
endmodule

bind cal_clock cal_clock_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr(wr), .addr(addr), .wdata(wdata),
  .bsy_t(bsy_t), .bsy_d(bsy_d), .commit_t(commit_t), .commit_d(commit_d),
  .pend_t(pend_t), .pend_d(pend_d), .time_word(time_word), .date_word(date_word)
);

// File: tb/cal_clock_bench.sv
module cal_clock_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;

  int checks = 0;
  int fails = 0;

  cal_clock u_cal_clock (.clk(clk), .rst_n(rst_n), .tick(tick), .wr(wr),
                         .addr(addr), .wdata(wdata), .rdata(rdata));

  always #5 clk = ~clk;

  // {time in, date in, time expected, date expected}: set both, one tick, read back
  localparam int NV = 13;
  localparam logic [127:0] VEC [NV] = '{
    {32'h00000000, 32'h00000101, 32'h00000001, 32'h00000101},
    {32'h0000003B, 32'h00000101, 32'h00000100, 32'h00000101},
    {32'h00003B3B, 32'h00000101, 32'h00010000, 32'h00000101},
    {32'h00173B3B, 32'h00000101, 32'h00000000, 32'h00000102},
    {32'h00173B3B, 32'h0000011F, 32'h00000000, 32'h00000201},
    {32'h00173B3B, 32'h0000041E, 32'h00000000, 32'h00000501},
    {32'h00173B3B, 32'h0000011E, 32'h00000000, 32'h0000011F},
    {32'h00173B3B, 32'h00000B1E, 32'h00000000, 32'h00000C01},
    {32'h00173B3B, 32'h0000021C, 32'h00000000, 32'h00000301},
    {32'h00173B3B, 32'h0040021C, 32'h00000000, 32'h0040021D},
    {32'h00173B3B, 32'h0040021D, 32'h00000000, 32'h00400301},
    {32'h00173B3B, 32'h00050C1F, 32'h00000000, 32'h00060101},
    {32'h00173B3B, 32'h003F0C1F, 32'h00000000, 32'h00000101}
  };
  localparam string VREQ [NV] = '{"R6", "R6", "R6", "R6", "R7", "R7", "R7", "R7",
                                  "R8", "R8", "R8", "R9", "R9"};

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(8'h14, v); check("R1 time", v, 32'h0);
    rd(8'h10, v); check("R1 date", v, 32'h00000101);
    rd(8'h00, v); check("R1 ctrl", v, 32'h0);

    // R10: idle cycles leave time and date alone
    repeat (5) @(negedge clk);
    rd(8'h14, v); check("R10 time idle", v, 32'h0);
    rd(8'h10, v); check("R10 date idle", v, 32'h00000101);

    // R4: time busy window, old value visible until commit
    wr_reg(8'h14, 32'h000A0B0C);
    rd(8'h00, v); check("R4 ctrl bit8 cycle1", v, 32'h00000100);
    rd(8'h14, v); check("R4 old time cycle1", v, 32'h0);
    @(negedge clk);
    rd(8'h00, v); check("R4 ctrl bit8 cycle2", v, 32'h00000100);
    rd(8'h14, v); check("R4 old time cycle2", v, 32'h0);
    @(negedge clk);
    rd(8'h00, v); check("R4 ctrl clear", v, 32'h0);
    rd(8'h14, v); check("R4 time committed", v, 32'h000A0B0C);

    // R4: date busy uses bit 7
    wr_reg(8'h10, 32'h00030405);
    rd(8'h00, v); check("R4 ctrl bit7", v, 32'h00000080);
    rd(8'h10, v); check("R4 old date", v, 32'h00000101);
    @(negedge clk);
    @(negedge clk);
    rd(8'h00, v); check("R4 ctrl bit7 clear", v, 32'h0);
    rd(8'h10, v); check("R4 date committed", v, 32'h00030405);

    // R5: second write while busy is dropped
    wr_reg(8'h14, 32'h00010203);
    wr_reg(8'h14, 32'h00040506);
    settle();
    rd(8'h14, v); check("R5 time first kept", v, 32'h00010203);
    wr_reg(8'h10, 32'h00020304);
    wr_reg(8'h10, 32'h00050607);
    settle();
    rd(8'h10, v); check("R5 date first kept", v, 32'h00020304);

    // R2, R3: field masks
    wr_reg(8'h14, 32'hFFFFFFFF);
    settle();
    rd(8'h14, v); check("R2 time mask", v, 32'h001F3F3F);
    wr_reg(8'h10, 32'hFFFFFFFF);
    settle();
    rd(8'h10, v); check("R3 date mask", v, 32'h007F0F1F);

    // R11: control read-only, unmapped addresses inert
    wr_reg(8'h00, 32'hFFFFFFFF);
    rd(8'h00, v); check("R11 ctrl write ignored", v, 32'h0);
    wr_reg(8'h08, 32'h12345678);
    rd(8'h08, v); check("R11 unmapped read", v, 32'h0);
    rd(8'h14, v); check("R11 time untouched", v, 32'h001F3F3F);
    rd(8'h10, v); check("R11 date untouched", v, 32'h007F0F1F);

    for (int i = 0; i < NV; i++) begin
      wr_reg(8'h14, VEC[i][127:96]);
      settle();
      wr_reg(8'h10, VEC[i][95:64]);
      settle();
      pulse_tick();
      rd(8'h14, v); check({VREQ[i], " time"}, v, VEC[i][63:32]);
      rd(8'h10, v); check({VREQ[i], " date"}, v, VEC[i][31:0]);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule